// File: doc/BRIEF.md
# Sense-Resistor Fault Delay Qualifier

This block turns four digitized current-comparator flags into latched protection faults. The classes are discharge overcurrent, a lower and a higher discharge short-circuit level, and charge short circuit. Each class waits for a programmable qualification time, counted in ticks of a slow timebase at about 30.5 µs per tick. The time comes from the delay code of that class and, for the two discharge short-circuit levels, from a shared bit that doubles the delay step. A flag that stays asserted for the whole time latches a fault. A discharge fault removes the discharge switch enable, and a charge short circuit removes the charge switch enable.

The block also scales the threshold codes for the external comparators into threshold magnitudes. These are given in units of 0.5 mV. A range bit halves both the base and the step. Faults, the enables and a record of the first class to trip all hold until a clear pulse arrives.

Top module: `sense_fault_qualifier`

## Requirements
- R1: After reset, fault_o is 0, dsg_en_o and chg_en_o are 1, and first_vld_o is 0.
- R2: Discharge overcurrent (flag bit 0) with delay code c needs N = (2c+1)*MS_TICKS ticks (MS_TICKS = 33 ticks per millisecond). Its fault bit rises at the clock edge that samples the N-th consecutive tick during which the flag is high, and not before.
- R3: Discharge short-circuit level 1 (flag bit 1) uses N = 2c ticks, or N = 4c when sc_dbl_i is 1. A fault with N = 0 trips on the first tick.
- R4: Discharge short-circuit level 2 (flag bit 2) uses N = c ticks, or N = 2c when sc_dbl_i is 1. N = 0 trips on the first tick.
- R5: Charge short circuit (flag bit 3) uses N = 2c ticks, whatever the value of sc_dbl_i.
- R6: A flag that goes low before its class trips discards the partial count, and the full count starts again when the flag returns.
- R7: Any of fault bits 0 to 2 drives dsg_en_o low and leaves chg_en_o high. Fault bit 3 drives chg_en_o low and leaves dsg_en_o high.
- R8: A fault stays set after its flag drops, until clr_i is high at a clock edge. clr_i takes priority over a trip in the same cycle and restarts all counts.
- R9: first_cls_o holds the class index (0 overcurrent, 1 short level 1, 2 short level 2, 3 charge short) of the first fault since the last clear. Among faults that trip in the same cycle, the lowest index wins. first_vld_o is 1 while any fault is latched, and first_cls_o does not change when later faults trip.
- R10: In 0.5 mV units, the discharge overcurrent threshold is 100+10c with rng_i = 0 and 50+5c with rng_i = 1. Each discharge short-circuit threshold is 200+100c with rng_i = 0 and 100+50c with rng_i = 1.
- R11: scc_thr_o is the two's-complement negative of the short-circuit formula of R10, applied to the charge short-circuit code.
- R12: A flag held high with no tick_i pulses never trips, even with a delay of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per slow-timebase period |
| clr_i | input | 1 | Clears faults, counts and first-trip record |
| flag_i | input | 4 | Comparator flags, index = class |
| oc_dly_i | input | CODE_W | Overcurrent delay code |
| sc1_dly_i | input | CODE_W | Short-circuit level 1 delay code |
| sc2_dly_i | input | CODE_W | Short-circuit level 2 delay code |
| scc_dly_i | input | CODE_W | Charge short-circuit delay code |
| sc_dbl_i | input | 1 | Doubles the discharge short-circuit delay step |
| rng_i | input | 1 | Halves threshold base and step |
| oc_thr_code_i | input | OC_TW | Overcurrent threshold code |
| sc1_thr_code_i | input | SC_TW | Short level 1 threshold code |
| sc2_thr_code_i | input | SC_TW | Short level 2 threshold code |
| scc_thr_code_i | input | SC_TW | Charge short threshold code |
| oc_thr_o | output | THR_W | Overcurrent threshold, 0.5 mV units |
| sc1_thr_o | output | THR_W | Short level 1 threshold |
| sc2_thr_o | output | THR_W | Short level 2 threshold |
| scc_thr_o | output | THR_W | Charge short threshold, signed |
| fault_o | output | 4 | Latched faults, index = class |
| dsg_en_o | output | 1 | Discharge switch enable |
| chg_en_o | output | 1 | Charge switch enable |
| first_vld_o | output | 1 | A first-trip record is held |
| first_cls_o | output | 2 | Class that tripped first |

## Verification
A count that drifts or fails to restart shows up as a fault bit rising one or more ticks early or late. The edges are checked on both sides of each expected tick, so an error of one tick is caught within the same delay window. A trip latch that leaks or a clear that fails shows on fault_o and on the switch enables in the cycle after the clear or after the flag drops. A first-trip record that is overwritten shows on first_cls_o as soon as the second class trips.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  localparam int NCLS = 4;

  typedef enum logic [1:0] {
    CLS_OC  = 2'd0,
    CLS_SC1 = 2'd1,
    CLS_SC2 = 2'd2,
    CLS_SCC = 2'd3
  } cls_e;

  // classes that gate the discharge switch
  localparam logic [NCLS-1:0] DSG_MASK = 4'b0111;
  localparam logic [NCLS-1:0] CHG_MASK = 4'b1000;
endpackage

// File: rtl/sfq_delay_map.sv
module sfq_delay_map
  import sfq_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int MS_TICKS = 33,
  parameter int CNT_W    = 10
) (
  input  logic [CODE_W-1:0]           oc_dly_i,
  input  logic [CODE_W-1:0]           sc1_dly_i,
  input  logic [CODE_W-1:0]           sc2_dly_i,
  input  logic [CODE_W-1:0]           scc_dly_i,
  input  logic                        sc_dbl_i,
  output logic [NCLS-1:0][CNT_W-1:0]  lim_o
);
  logic [31:0] oc_t, sc1_t, sc2_t, scc_t;

  always_comb begin
    oc_t  = (32'(oc_dly_i) * 32'd2 + 32'd1) * 32'(MS_TICKS);
    sc1_t = sc_dbl_i ? (32'(sc1_dly_i) << 2) : (32'(sc1_dly_i) << 1);
    sc2_t = sc_dbl_i ? (32'(sc2_dly_i) << 1) : 32'(sc2_dly_i);
    scc_t = 32'(scc_dly_i) << 1;
    lim_o[CLS_OC]  = oc_t[CNT_W-1:0];
    lim_o[CLS_SC1] = sc1_t[CNT_W-1:0];
    lim_o[CLS_SC2] = sc2_t[CNT_W-1:0];
    lim_o[CLS_SCC] = scc_t[CNT_W-1:0];
  end
endmodule

// File: rtl/sfq_thr_map.sv
module sfq_thr_map #(
  parameter int OC_TW = 5,
  parameter int SC_TW = 3,
  parameter int THR_W = 12
) (
  input  logic                    rng_i,
  input  logic [OC_TW-1:0]        oc_code_i,
  input  logic [SC_TW-1:0]        sc1_code_i,
  input  logic [SC_TW-1:0]        sc2_code_i,
  input  logic [SC_TW-1:0]        scc_code_i,
  output logic [THR_W-1:0]        oc_thr_o,
  output logic [THR_W-1:0]        sc1_thr_o,
  output logic [THR_W-1:0]        sc2_thr_o,
  output logic signed [THR_W-1:0] scc_thr_o
);
  // thresholds in 0.5 mV units
  function automatic logic [THR_W-1:0] sc_mag(input logic [SC_TW-1:0] c, input logic r);
    logic [31:0] v;
    v = r ? (32'd100 + 32'(c) * 32'd50) : (32'd200 + 32'(c) * 32'd100);
    return v[THR_W-1:0];
  endfunction

  logic [31:0]      oc_v;
  logic [THR_W-1:0] scc_mag;

  always_comb begin
    oc_v      = rng_i ? (32'd50 + 32'(oc_code_i) * 32'd5) : (32'd100 + 32'(oc_code_i) * 32'd10);
    oc_thr_o  = oc_v[THR_W-1:0];
    sc1_thr_o = sc_mag(sc1_code_i, rng_i);
    sc2_thr_o = sc_mag(sc2_code_i, rng_i);
    scc_mag   = sc_mag(scc_code_i, rng_i);
    scc_thr_o = -$signed(scc_mag);
  end
endmodule

// File: rtl/sfq_qual_chan.sv
module sfq_qual_chan #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             flag_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             trip_o,
  output logic             set_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             trip_q;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  // trips on the max(lim,1)-th consecutive qualified tick
  assign set_o   = tick_i & flag_i & ~trip_q & ~clr_i & (cnt_inc >= {1'b0, lim_i});
  assign trip_o  = trip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      if (set_o) trip_q <= 1'b1;
      if (!flag_i) cnt_q <= '0;
      else if (tick_i && !trip_q && !set_o) cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end

  a_r2_trip_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_o) |-> ($past(tick_i) && $past(flag_i)));

  a_r8_trip_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_o && !clr_i) |=> trip_o);

  a_r6_restart_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_o && !$past(flag_i)) |-> (lim_i <= CNT_W'(1)));

  a_r12_no_tick_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(trip_o) || !trip_o);
endmodule

// File: rtl/sense_fault_qualifier.sv
module sense_fault_qualifier
  import sfq_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int MS_TICKS = 33,
  parameter int OC_TW    = 5,
  parameter int SC_TW    = 3,
  parameter int THR_W    = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    clr_i,
  input  logic [NCLS-1:0]         flag_i,
  input  logic [CODE_W-1:0]       oc_dly_i,
  input  logic [CODE_W-1:0]       sc1_dly_i,
  input  logic [CODE_W-1:0]       sc2_dly_i,
  input  logic [CODE_W-1:0]       scc_dly_i,
  input  logic                    sc_dbl_i,
  input  logic                    rng_i,
  input  logic [OC_TW-1:0]        oc_thr_code_i,
  input  logic [SC_TW-1:0]        sc1_thr_code_i,
  input  logic [SC_TW-1:0]        sc2_thr_code_i,
  input  logic [SC_TW-1:0]        scc_thr_code_i,
  output logic [THR_W-1:0]        oc_thr_o,
  output logic [THR_W-1:0]        sc1_thr_o,
  output logic [THR_W-1:0]        sc2_thr_o,
  output logic signed [THR_W-1:0] scc_thr_o,
  output logic [NCLS-1:0]         fault_o,
  output logic                    dsg_en_o,
  output logic                    chg_en_o,
  output logic                    first_vld_o,
  output logic [1:0]              first_cls_o
);
  localparam int MAX_TICKS = (2 * (2 ** CODE_W - 1) + 1) * MS_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [NCLS-1:0][CNT_W-1:0] lim;
  logic [NCLS-1:0]            trip, set;
  logic                       vld_q;
  cls_e                       cls_q, pick;

  sfq_delay_map #(.CODE_W(CODE_W), .MS_TICKS(MS_TICKS), .CNT_W(CNT_W)) i_dmap (
    .oc_dly_i (oc_dly_i),
    .sc1_dly_i(sc1_dly_i),
    .sc2_dly_i(sc2_dly_i),
    .scc_dly_i(scc_dly_i),
    .sc_dbl_i (sc_dbl_i),
    .lim_o    (lim)
  );

  sfq_thr_map #(.OC_TW(OC_TW), .SC_TW(SC_TW), .THR_W(THR_W)) i_tmap (
    .rng_i     (rng_i),
    .oc_code_i (oc_thr_code_i),
    .sc1_code_i(sc1_thr_code_i),
    .sc2_code_i(sc2_thr_code_i),
    .scc_code_i(scc_thr_code_i),
    .oc_thr_o  (oc_thr_o),
    .sc1_thr_o (sc1_thr_o),
    .sc2_thr_o (sc2_thr_o),
    .scc_thr_o (scc_thr_o)
  );

  for (genvar g = 0; g < NCLS; g++) begin : g_chan
    sfq_qual_chan #(.CNT_W(CNT_W)) i_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick_i),
      .clr_i (clr_i),
      .flag_i(flag_i[g]),
      .lim_i (lim[g]),
      .trip_o(trip[g]),
      .set_o (set[g])
    );
  end

  // lowest index wins among simultaneous trips
  always_comb begin
    pick = CLS_OC;
    for (int i = NCLS - 1; i >= 0; i--) begin
      if (set[i]) pick = cls_e'(2'(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      cls_q <= CLS_OC;
    end else if (clr_i) begin
      vld_q <= 1'b0;
      cls_q <= CLS_OC;
    end else if (!vld_q && (|set)) begin
      vld_q <= 1'b1;
      cls_q <= pick;
    end
  end

  assign fault_o     = trip;
  assign dsg_en_o    = ~|(trip & DSG_MASK);
  assign chg_en_o    = ~|(trip & CHG_MASK);
  assign first_vld_o = vld_q;
  assign first_cls_o = cls_q;

  a_r7_dsg_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fault_o[2:0]) |-> !dsg_en_o);

  a_r7_chg_independent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o[3] |-> chg_en_o);

  a_r9_vld_tracks_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_vld_o == (|fault_o));

  a_r9_first_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_vld_o && !clr_i) |=> ($stable(first_cls_o) && first_vld_o));

  a_r11_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scc_thr_code_i == sc1_thr_code_i) |-> (scc_thr_o == -$signed(sc1_thr_o)));
endmodule

// File: tb/test_sense_fault_qualifier.sv
module test_sense_fault_qualifier;
  localparam int CLK_PERIOD = 10;
  localparam int MS_T = 33;

  logic        clk_i = 0, rst_ni = 0, tick_i = 0, clr_i = 0;
  logic [3:0]  flag_i = '0;
  logic [3:0]  oc_dly_i = '0, sc1_dly_i = '0, sc2_dly_i = '0, scc_dly_i = '0;
  logic        sc_dbl_i = 0, rng_i = 0;
  logic [4:0]  oc_thr_code_i = '0;
  logic [2:0]  sc1_thr_code_i = '0, sc2_thr_code_i = '0, scc_thr_code_i = '0;
  logic [11:0] oc_thr_o, sc1_thr_o, sc2_thr_o;
  logic signed [11:0] scc_thr_o;
  logic [3:0]  fault_o;
  logic        dsg_en_o, chg_en_o, first_vld_o;
  logic [1:0]  first_cls_o;

  int nvec = 0, nerr = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  sense_fault_qualifier i_sense_fault_qualifier (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i) tick_i = 1;
      @(negedge clk_i) tick_i = 0;
    end
  endtask

  task automatic clear_all();
    @(negedge clk_i);
    flag_i = '0; sc_dbl_i = 0; clr_i = 1;
    @(negedge clk_i) clr_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 fault", 32'(fault_o), 0);
    chk("R1 dsg_en", 32'(dsg_en_o), 1);
    chk("R1 chg_en", 32'(chg_en_o), 1);
    chk("R1 first_vld", 32'(first_vld_o), 0);
  endtask

  task automatic t_thresholds();
    @(negedge clk_i);
    oc_thr_code_i = 5'd6; sc1_thr_code_i = 3'd3; sc2_thr_code_i = 3'd0; scc_thr_code_i = 3'd2; rng_i = 0;
    #1;
    chk("R10 oc rng0", 32'(oc_thr_o), 160);
    chk("R10 sc1 rng0", 32'(sc1_thr_o), 500);
    chk("R10 sc2 rng0", 32'(sc2_thr_o), 200);
    chk("R11 scc rng0", 32'(scc_thr_o), 32'(-400));
    rng_i = 1;
    #1;
    chk("R10 oc rng1", 32'(oc_thr_o), 80);
    chk("R10 sc1 rng1", 32'(sc1_thr_o), 250);
    chk("R11 scc rng1", 32'(scc_thr_o), 32'(-200));
    rng_i = 0;
  endtask

  task automatic t_oc();
    clear_all();
    oc_dly_i = 4'd0; flag_i = 4'b0001;
    ticks(MS_T - 1);
    chk("R2 oc c0 early", 32'(fault_o), 0);
    ticks(1);
    chk("R2 oc c0 trip", 32'(fault_o), 1);
    chk("R7 dsg_en low", 32'(dsg_en_o), 0);
    chk("R7 chg_en kept", 32'(chg_en_o), 1);
    clear_all();
    oc_dly_i = 4'd1; flag_i = 4'b0001;
    ticks(3 * MS_T - 1);
    chk("R2 oc c1 early", 32'(fault_o), 0);
    ticks(1);
    chk("R2 oc c1 trip", 32'(fault_o), 1);
  endtask

  task automatic t_sc1();
    clear_all();
    sc1_dly_i = 4'd3; flag_i = 4'b0010;
    ticks(5);
    chk("R3 sc1 x1 early", 32'(fault_o), 0);
    ticks(1);
    chk("R3 sc1 x1 trip", 32'(fault_o), 2);
    clear_all();
    sc_dbl_i = 1; flag_i = 4'b0010;
    ticks(11);
    chk("R3 sc1 x2 early", 32'(fault_o), 0);
    ticks(1);
    chk("R3 sc1 x2 trip", 32'(fault_o), 2);
  endtask

  task automatic t_sc2();
    clear_all();
    sc2_dly_i = 4'd5; flag_i = 4'b0100;
    ticks(4);
    chk("R4 sc2 x1 early", 32'(fault_o), 0);
    ticks(1);
    chk("R4 sc2 x1 trip", 32'(fault_o), 4);
    clear_all();
    sc_dbl_i = 1; flag_i = 4'b0100;
    ticks(9);
    chk("R4 sc2 x2 early", 32'(fault_o), 0);
    ticks(1);
    chk("R4 sc2 x2 trip", 32'(fault_o), 4);
    clear_all();
    sc2_dly_i = 4'd0; flag_i = 4'b0100;
    ticks(1);
    chk("R4 sc2 zero delay", 32'(fault_o), 4);
  endtask

  task automatic t_scc();
    clear_all();
    scc_dly_i = 4'd4; sc_dbl_i = 1; flag_i = 4'b1000;
    ticks(7);
    chk("R5 scc early", 32'(fault_o), 0);
    ticks(1);
    chk("R5 scc trip ignores dbl", 32'(fault_o), 8);
    chk("R7 chg_en low", 32'(chg_en_o), 0);
    chk("R7 dsg_en kept", 32'(dsg_en_o), 1);
  endtask

  task automatic t_drop();
    clear_all();
    sc2_dly_i = 4'd5; flag_i = 4'b0100;
    ticks(4);
    @(negedge clk_i) flag_i = 4'b0000;
    @(negedge clk_i) flag_i = 4'b0100;
    ticks(4);
    chk("R6 partial count lost", 32'(fault_o), 0);
    ticks(1);
    chk("R6 full count trips", 32'(fault_o), 4);
  endtask

  task automatic t_no_tick();
    clear_all();
    sc1_dly_i = 4'd0; flag_i = 4'b0010;
    repeat (12) @(negedge clk_i);
    chk("R12 no tick no trip", 32'(fault_o), 0);
    ticks(1);
    chk("R12 first tick trips", 32'(fault_o), 2);
  endtask

  task automatic t_latch();
    clear_all();
    sc1_dly_i = 4'd3; flag_i = 4'b0010;
    ticks(6);
    @(negedge clk_i) flag_i = 4'b0000;
    ticks(3);
    chk("R8 held after flag drop", 32'(fault_o), 2);
    @(negedge clk_i) flag_i = 4'b0010;
    ticks(5);
    // clear and tick in the same cycle: clear wins
    @(negedge clk_i) begin clr_i = 1; tick_i = 1; end
    @(negedge clk_i) begin clr_i = 0; tick_i = 0; end
    chk("R8 cleared", 32'(fault_o), 0);
    chk("R8 dsg_en back", 32'(dsg_en_o), 1);
    ticks(5);
    chk("R8 count restarted", 32'(fault_o), 0);
    ticks(1);
    chk("R8 requalified", 32'(fault_o), 2);
  endtask

  task automatic t_first();
    clear_all();
    sc2_dly_i = 4'd0; scc_dly_i = 4'd0; flag_i = 4'b1100;
    ticks(1);
    chk("R9 tie lowest", 32'(first_cls_o), 2);
    chk("R9 vld", 32'(first_vld_o), 1);
    clear_all();
    chk("R9 vld cleared", 32'(first_vld_o), 0);
    flag_i = 4'b1000;
    ticks(1);
    chk("R9 scc first", 32'(first_cls_o), 3);
    sc1_dly_i = 4'd0; flag_i = 4'b1010;
    ticks(1);
    chk("R9 later fault latched", 32'(fault_o), 4'b1010);
    chk("R9 first kept", 32'(first_cls_o), 3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    @(negedge clk_i) rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_thresholds();
    t_oc();
    t_sc1();
    t_sc2();
    t_scc();
    t_drop();
    t_no_tick();
    t_latch();
    t_first();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule